// File: doc/BRIEF.md
# Vector Lane Shift-Right-and-Insert Unit

This block is a SIMD datapath that merges a logically right-shifted source vector into an existing destination vector, lane by lane. A packed 7-bit control group sets both the lane width and the shift count: a 2-bit upper size field, a 2-bit lower size field and a 3-bit low immediate. In every lane the destination keeps its high bits, and its low bits are replaced by the source lane shifted right. The vector length is a parameter that is a multiple of 128 bits.

Operands are captured on a clock edge where `in_valid` is high. The merged vector appears on the registered output one clock later, together with `out_valid`. The all-zero size code is reserved. For that code the unit raises `out_undef` and returns the destination unchanged. Output timing is governed by a two-state machine. `ST_IDLE` means no result is presented. `ST_RESULT` means a result is presented. The machine takes `GO_RESULT` (from either state, whenever `in_valid` is high) and `GO_IDLE` (whenever `in_valid` is low). Synchronous reset forces `ST_IDLE`.

Top module: `vec_shr_insert`

## Requirements
- R1: The 4-bit size code is {size_hi, size_lo}, with size_hi in the upper two bits. The lane width comes from the highest set bit of that code: 0001 gives 8 bits, 001x gives 16, 01xx gives 32 and 1xxx gives 64.
- R2: The shift count is 2*width minus the unsigned 7-bit value {size_code, imm_lo}, with imm_lo in the low three bits. For every legal code this lies between 1 and the lane width inclusive.
- R3: Each result lane equals (dst AND NOT mask) OR (src >> shift), where mask is an all-ones lane logically shifted right by the shift count.
- R4: All lanes are treated identically, with no predicate. There are VL/width lanes, and lane e occupies bits [e*width +: width] of every vector.
- R5: When the shift count equals the lane width, the result lane equals the destination lane unchanged.
- R6: Size code 0000 is reserved. The result is flagged with out_undef=1 and out_vec equals dst_vec unchanged.
- R7: Inputs sampled on an edge with in_valid=1 produce out_valid=1 and their result on out_vec one clock later. After an edge with in_valid=0, out_valid is 0. out_undef is only ever 1 together with out_valid.
- R8: Synchronous reset drives out_valid and out_undef to 0 and out_vec to zero, regardless of in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and control are valid this cycle |
| size_hi | input | 2 | Upper half of the size code |
| size_lo | input | 2 | Lower half of the size code |
| imm_lo | input | 3 | Low immediate bits of the shift encoding |
| src_vec | input | VL | Source vector to be shifted |
| dst_vec | input | VL | Current destination vector |
| out_valid | output | 1 | Result presented on out_vec |
| out_undef | output | 1 | Result came from the reserved size code |
| out_vec | output | VL | Merged destination vector |

## Verification
The assertions assume that the control fields and both vectors are free of unknown values whenever they are sampled. The immediate checks on shift range and full-shift pass-through are skipped while any of their inputs is unknown. The clocked checks assume that the reset is held from time zero until the first edge. The bench drives every input on the falling edge with defined values throughout. It asserts reset at time zero, and it sweeps all 16 size codes and all 8 immediate values with fixed and random vectors. Every shift therefore falls in the decoded legal range, and the reserved code is covered without unknowns.

// File: rtl/shri_pkg.sv
package shri_pkg;
    // Lane width selector decoded from the size code
    typedef enum logic [1:0] {
        LW_8  = 2'd0,
        LW_16 = 2'd1,
        LW_32 = 2'd2,
        LW_64 = 2'd3
    } lane_w_e;

    // Output-presentation state machine
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } out_state_e;

    localparam int unsigned NUM_WIDTHS = 4;
    localparam int unsigned SHAMT_W    = 8;
endpackage

// File: rtl/shri_decode.sv
module shri_decode
    import shri_pkg::*;
(
    input  logic [1:0]         size_hi,
    input  logic [1:0]         size_lo,
    input  logic [2:0]         imm_lo,
    output lane_w_e            lane_w,
    output logic [SHAMT_W-1:0] shamt,
    output logic               undef
);
    logic [3:0]         size_code;
    logic [SHAMT_W-1:0] twice_w;
    logic [SHAMT_W-1:0] width_bits;

    assign size_code = {size_hi, size_lo};

    always_comb begin
        undef   = 1'b0;
        lane_w  = LW_8;
        twice_w = 8'd16;
        if (size_code[3]) begin
            lane_w  = LW_64;
            twice_w = 8'd128;
        end else if (size_code[2]) begin
            lane_w  = LW_32;
            twice_w = 8'd64;
        end else if (size_code[1]) begin
            lane_w  = LW_16;
            twice_w = 8'd32;
        end else if (!size_code[0]) begin
            undef   = 1'b1;
        end
        width_bits = twice_w >> 1;
        shamt      = undef ? '0 : (twice_w - {1'b0, size_code, imm_lo});
    end

    // Shift stays in 1..width for every legal code
    always_comb begin
        if (!$isunknown({size_code, imm_lo}) && !undef) begin
            assert_shift_range_R2: assert (shamt >= 8'd1 && shamt <= width_bits)
                else $error("shift %0d outside 1..%0d", shamt, width_bits);
        end
    end
endmodule

// File: rtl/shri_lane.sv
module shri_lane
    import shri_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]       dst,
    input  logic [W-1:0]       src,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [W-1:0]       res
);
    logic [W-1:0] keep_low;

    assign keep_low = {W{1'b1}} >> shamt;
    assign res      = (dst & ~keep_low) | (src >> shamt);

    // A full-width shift leaves the destination lane untouched
    always_comb begin
        if (!$isunknown({dst, src, shamt}) && shamt == SHAMT_W'(W)) begin
            assert_full_shift_keeps_R5: assert (res == dst)
                else $error("full shift altered lane");
        end
    end
endmodule

// File: rtl/shri_lane_array.sv
module shri_lane_array
    import shri_pkg::*;
#(
    parameter int unsigned VL = 256,
    parameter int unsigned W  = 8
) (
    input  logic [VL-1:0]      dst_vec,
    input  logic [VL-1:0]      src_vec,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [VL-1:0]      res_vec
);
    localparam int unsigned LANES = VL / W;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        shri_lane #(.W(W)) u_lane (
            .dst   (dst_vec[e*W +: W]),
            .src   (src_vec[e*W +: W]),
            .shamt (shamt),
            .res   (res_vec[e*W +: W])
        );
    end
endmodule

// File: rtl/vec_shr_insert.sv
module vec_shr_insert
    import shri_pkg::*;
#(
    parameter int unsigned VL = 256
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    size_hi,
    input  logic [1:0]    size_lo,
    input  logic [2:0]    imm_lo,
    input  logic [VL-1:0] src_vec,
    input  logic [VL-1:0] dst_vec,
    output logic          out_valid,
    output logic          out_undef,
    output logic [VL-1:0] out_vec
);
    lane_w_e            dec_w;
    logic [SHAMT_W-1:0] dec_shamt;
    logic               dec_undef;
    logic [VL-1:0]      by_width [NUM_WIDTHS];
    logic [VL-1:0]      merged;
    out_state_e         state, state_nx;

    shri_decode u_dec (
        .size_hi (size_hi),
        .size_lo (size_lo),
        .imm_lo  (imm_lo),
        .lane_w  (dec_w),
        .shamt   (dec_shamt),
        .undef   (dec_undef)
    );

    // One lane array per element width; the decoded width picks one
    for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
        shri_lane_array #(.VL(VL), .W(8 << k)) u_arr (
            .dst_vec (dst_vec),
            .src_vec (src_vec),
            .shamt   (dec_shamt),
            .res_vec (by_width[k])
        );
    end

    assign merged = dec_undef ? dst_vec : by_width[dec_w];

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // Transitions: GO_RESULT on in_valid, GO_IDLE otherwise
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_nx = in_valid ? ST_RESULT : ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            out_vec   <= '0;
            out_undef <= 1'b0;
        end else if (in_valid) begin
            out_vec   <= merged;
            out_undef <= dec_undef;
        end else begin
            out_undef <= 1'b0;
        end
    end

    assign out_valid = (state == ST_RESULT);

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drops_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_undef_gated_R7: assert property (@(posedge clk) disable iff (rst)
        out_undef |-> out_valid);
    assert_reserved_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && {size_hi, size_lo} == 4'd0) |=> out_undef);
    assert_reserved_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        out_undef |-> (out_vec == $past(dst_vec)));
    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_undef && out_vec == '0));
endmodule

// File: tb/vec_shr_insert_tb.sv
module vec_shr_insert_tb;
    localparam int CLK_PERIOD = 10;
    localparam int VL = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    size_hi = '0;
    logic [1:0]    size_lo = '0;
    logic [2:0]    imm_lo = '0;
    logic [VL-1:0] src_vec = '0;
    logic [VL-1:0] dst_vec = '0;
    logic          out_valid;
    logic          out_undef;
    logic [VL-1:0] out_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_shr_insert #(.VL(VL)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .size_hi(size_hi), .size_lo(size_lo), .imm_lo(imm_lo),
        .src_vec(src_vec), .dst_vec(dst_vec),
        .out_valid(out_valid), .out_undef(out_undef), .out_vec(out_vec)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [VL-1:0] act, input logic [VL-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int width_of(input logic [3:0] code);
        if (code[3])      return 64;
        else if (code[2]) return 32;
        else if (code[1]) return 16;
        else              return 8;
    endfunction

    function automatic logic [VL-1:0] model(input logic [3:0] code, input logic [2:0] im,
                                            input logic [VL-1:0] s, input logic [VL-1:0] d);
        logic [VL-1:0] r;
        logic [63:0] ones, ls, ld, lr, msk;
        int es, sh;
        if (code == 4'd0) return d;
        es   = width_of(code);
        sh   = 2*es - int'({code, im});
        ones = (es == 64) ? {64{1'b1}} : ((64'd1 << es) - 64'd1);
        msk  = ones >> sh;
        r    = '0;
        for (int e = 0; e < VL/es; e++) begin
            ls = 64'(s >> (e*es)) & ones;
            ld = 64'(d >> (e*es)) & ones;
            lr = (ld & ~msk & ones) | (ls >> sh);
            r  = r | (VL'(lr) << (e*es));
        end
        return r;
    endfunction

    function automatic logic [VL-1:0] rand_vec();
        logic [VL-1:0] v;
        for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [VL-1:0] exp;
        logic [3:0] code;
        string tag;
        int es, sh;

        // R8: reset dominates a valid request
        in_valid = 1'b1;
        src_vec  = rand_vec();
        dst_vec  = rand_vec();
        size_hi  = 2'b01;
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_undef && out_vec == '0, "R8 reset state",
            {out_valid, out_undef, out_vec[VL-3:0]}, '0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R7 idle after reset", VL'(out_valid), '0);

        // Full sweep: every size code, every immediate, several data patterns
        in_valid = 1'b1;
        for (int c = 0; c < 16; c++) begin
            for (int im = 0; im < 8; im++) begin
                for (int p = 0; p < 4; p++) begin
                    code = 4'(c);
                    {size_hi, size_lo} = code;
                    imm_lo = 3'(im);
                    case (p)
                        0: begin src_vec = '1; dst_vec = '0; end
                        1: begin src_vec = '0; dst_vec = '1; end
                        default: begin src_vec = rand_vec(); dst_vec = rand_vec(); end
                    endcase
                    exp = model(code, 3'(im), src_vec, dst_vec);
                    es  = width_of(code);
                    sh  = 2*es - int'({code, 3'(im)});
                    if (code == 4'd0)  tag = "R6 reserved passthrough";
                    else if (sh == es) tag = "R5 full shift keeps dst";
                    else               tag = "R1 R2 R3 R4 lane merge";
                    @(negedge clk);
                    chk(out_vec == exp, tag, out_vec, exp);
                    chk(out_valid && (out_undef == (code == 4'd0)), "R6 R7 flags",
                        VL'({out_valid, out_undef}), VL'({1'b1, code == 4'd0}));
                end
            end
        end

        // R7: valid drops one cycle after in_valid drops
        in_valid = 1'b0;
        @(negedge clk);
        chk(!out_valid && !out_undef, "R7 valid drop", VL'({out_valid, out_undef}), '0);

        // R8: mid-run reset with a reserved request pending
        {size_hi, size_lo} = 4'd0;
        in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_undef && out_vec == '0, "R8 mid-run reset",
            {out_valid, out_undef, out_vec[VL-3:0]}, '0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule